// File: doc/BRIEF.md
# Least-Cushion Crossbar Matching Scheduler

This block computes a one-to-one input-to-output matching for the crossbar of a small N x N switch that queues cells both at the inputs and at the outputs. For every input/output pair it takes a cushion value and an urgency rank. The cushion is the number of cells already waiting at that output that leave ahead of the pair's best cell. The urgency rank orders the candidate cells within one output, and a lower rank departs earlier. An upstream unit supplies both matrices. Computing the cushions, buffering the cells and moving the data all happen outside this block.

A start pulse loads both matrices. After that the scheduler runs one matching iteration per clock. Each iteration finds the smallest cushion still present and takes the output column that holds it. Within that column it grants the most urgent input that still has a cell there, then removes that input row and that output column from the matrix. Matching ends when no pair with a cell remains or when every port has been matched. A done pulse then marks the result, and the result is shown both per input and per output.

The block is invoked twice per switch slot to give a fabric speedup of two. A phase input tells the block which invocation it is. The block returns a cut-through flag with the result: a cell matched in the first invocation may leave its output in the same slot, and a cell matched in the second invocation leaves no earlier than the next slot.

Top module: `lcm_scheduler`

## Requirements
- R1: After reset, busy_o and done_o are low and every bit of in_vld_o and out_vld_o is low.
- R2: A cushion equal to the all-ones code (15 for the default 4-bit width) means the pair holds no cell, and that pair is never granted.
- R3: Each iteration picks the output column that holds the smallest cushion among the remaining rows and columns. When several columns hold that smallest value, the lowest column index wins.
- R4: Within the chosen column, the grant goes to the remaining input with a cell in that column that has the lowest urgency rank, even if that input does not hold the smallest cushion. Equal ranks go to the lowest input index.
- R5: A matched input and a matched output take no part in later iterations. For every input with in_vld_o[i] set to 1 and in_port_o field i equal to j, out_vld_o[j] is 1 and out_port_o field j equals i, and the reverse also holds.
- R6: Matching stops when no remaining pair has a cell. If m < N pairs were matched, done_o is high in the (m+1)-th cycle after the start edge.
- R7: When N pairs are matched, done_o is high in the N-th cycle after the start edge, so a full match never takes more than N cycles. done_o is a one-cycle pulse.
- R8: A start_i pulse while busy_o is high is ignored: the matrices presented with it have no effect on the result.
- R9: cut_thru_o is 1 when phase_i was 0 at the accepted start, and 0 when phase_i was 1. It is held with the result.
- R10: The grant outputs and cut_thru_o keep their values after done_o until the next accepted start, whatever the matrix inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load matrices and begin matching (ignored while busy) |
| phase_i | input | 1 | 0 = first invocation of the slot, 1 = second |
| cushion_i | input | N*N*CW | Cushion of pair (i,j) at bits [(i*N+j)*CW +: CW]; all ones means no cell |
| urgency_i | input | N*N*RW | Urgency rank of pair (i,j) at bits [(i*N+j)*RW +: RW]; lower is more urgent |
| busy_o | output | 1 | Matching in progress |
| done_o | output | 1 | One-cycle pulse when the result is complete |
| cut_thru_o | output | 1 | Result may depart in the current slot |
| in_vld_o | output | N | Input i holds a grant |
| in_port_o | output | N*IW | Field i: output granted to input i |
| out_vld_o | output | N | Output j holds a grant |
| out_port_o | output | N*IW | Field j: input granted to output j |

## Verification
The hardest case to reach from the ports is a matrix where the choice between tied columns, or the choice of a more urgent row over the row holding the minimum, changes which later pairs can still be matched. Random matrices produce this only now and then. Directed matrices are therefore built for two situations: a tie on the minimum across columns that share one row, and a column where the minimum-cushion row carries a worse rank than another row. A separate case re-asserts start with a different matrix while a match is running, and the bench checks that the result still follows the first matrix.

// File: rtl/lcm_pkg.sv
// Package: shared state type for the least-cushion matching scheduler.
// Assumes nothing beyond being compiled before the modules that import it.
package lcm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } lcm_state_e;
endpackage

// File: rtl/lcm_min_select.sv
// Module: finds the smallest cushion over the rows and columns that are not
// yet matched, and the lowest column index holding that value.
// Assumes the all-ones cushion marks an empty pair; found_o is low when only
// empty pairs remain.
module lcm_min_select #(
    parameter int N  = 4,
    parameter int CW = 4,
    parameter int IW = 2
) (
    input  logic [N*N*CW-1:0] cush_i,
    input  logic [N-1:0]      row_used_i,
    input  logic [N-1:0]      col_used_i,
    output logic              found_o,
    output logic [CW-1:0]     min_o,
    output logic [IW-1:0]     col_o
);
    localparam logic [CW-1:0] INF = {CW{1'b1}};

    logic [CW-1:0] best;
    logic [IW-1:0] best_col;

    // Column-major scan with strict less-than, so the lowest column wins ties.
    always_comb begin
        best     = INF;
        best_col = '0;
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                if (!row_used_i[i] && !col_used_i[j] &&
                    (cush_i[(i*N+j)*CW +: CW] < best)) begin
                    best     = cush_i[(i*N+j)*CW +: CW];
                    best_col = IW'(j);
                end
            end
        end
    end

    // Drive the outputs from the scan result.
    always_comb begin
        min_o   = best;
        col_o   = best_col;
        found_o = (best != INF);
    end
endmodule

// File: rtl/lcm_urgency_pick.sv
// Module: within one chosen column, selects the remaining input whose cell is
// most urgent (lowest rank); equal ranks go to the lowest input index.
// Assumes only inputs with a non-empty cushion in that column compete.
module lcm_urgency_pick #(
    parameter int N  = 4,
    parameter int CW = 4,
    parameter int RW = 3,
    parameter int IW = 2
) (
    input  logic [N*N*CW-1:0] cush_i,
    input  logic [N*N*RW-1:0] urg_i,
    input  logic [N-1:0]      row_used_i,
    input  logic [IW-1:0]     col_i,
    output logic              found_o,
    output logic [IW-1:0]     row_o
);
    localparam logic [CW-1:0] INF = {CW{1'b1}};

    logic [RW-1:0] best_rank;

    // Row scan with strict less-than on rank, so the lowest input wins ties.
    always_comb begin
        found_o   = 1'b0;
        row_o     = '0;
        best_rank = '1;
        for (int i = 0; i < N; i++) begin
            if (!row_used_i[i] &&
                (cush_i[(i*N+int'(col_i))*CW +: CW] != INF) &&
                (!found_o || (urg_i[(i*N+int'(col_i))*RW +: RW] < best_rank))) begin
                found_o   = 1'b1;
                row_o     = IW'(i);
                best_rank = urg_i[(i*N+int'(col_i))*RW +: RW];
            end
        end
    end
endmodule

// File: rtl/lcm_scheduler.sv
// Module: top of the least-cushion / most-urgent crossbar scheduler.
// On an accepted start it loads the cushion and urgency matrices, then makes
// one match per cycle: least cushion picks the column, urgency picks the row,
// and the matched row and column leave the matrix. It stops on an all-empty
// remainder or after N matches. Assumes start is ignored while busy.
module lcm_scheduler #(
    parameter int N  = 4,
    parameter int CW = 4,
    parameter int RW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              phase_i,
    input  logic [N*N*CW-1:0] cushion_i,
    input  logic [N*N*RW-1:0] urgency_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              cut_thru_o,
    output logic [N-1:0]      in_vld_o,
    output logic [N*((N>1)?$clog2(N):1)-1:0] in_port_o,
    output logic [N-1:0]      out_vld_o,
    output logic [N*((N>1)?$clog2(N):1)-1:0] out_port_o
);
    import lcm_pkg::*;

    localparam int IW    = (N > 1) ? $clog2(N) : 1;
    localparam int CNT_W = $clog2(N + 1);
    localparam logic [CW-1:0]    INF      = {CW{1'b1}};
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(N - 1);

    lcm_state_e        state_q;
    logic [N*N*CW-1:0] cush_q;
    logic [N*N*RW-1:0] urg_q;
    logic [N-1:0]      row_used_q;
    logic [N-1:0]      col_used_q;
    logic [CNT_W-1:0]  match_cnt_q;
    logic              done_q;
    logic              cut_q;
    logic [N-1:0]      in_vld_q;
    logic [N*IW-1:0]   in_port_q;
    logic [N-1:0]      out_vld_q;
    logic [N*IW-1:0]   out_port_q;

    logic              min_found;
    logic [CW-1:0]     min_val;
    logic [IW-1:0]     min_col;
    logic              pick_found;
    logic [IW-1:0]     pick_row;

    lcm_min_select #(.N(N), .CW(CW), .IW(IW)) u_min (
        .cush_i     (cush_q),
        .row_used_i (row_used_q),
        .col_used_i (col_used_q),
        .found_o    (min_found),
        .min_o      (min_val),
        .col_o      (min_col)
    );

    lcm_urgency_pick #(.N(N), .CW(CW), .RW(RW), .IW(IW)) u_pick (
        .cush_i     (cush_q),
        .urg_i      (urg_q),
        .row_used_i (row_used_q),
        .col_i      (min_col),
        .found_o    (pick_found),
        .row_o      (pick_row)
    );

    // Control and result registers: load on start, one match per running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cush_q      <= '1;
            urg_q       <= '0;
            row_used_q  <= '0;
            col_used_q  <= '0;
            match_cnt_q <= '0;
            done_q      <= 1'b0;
            cut_q       <= 1'b0;
            in_vld_q    <= '0;
            in_port_q   <= '0;
            out_vld_q   <= '0;
            out_port_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q     <= ST_RUN;
                        cush_q      <= cushion_i;
                        urg_q       <= urgency_i;
                        row_used_q  <= '0;
                        col_used_q  <= '0;
                        match_cnt_q <= '0;
                        cut_q       <= ~phase_i;
                        in_vld_q    <= '0;
                        in_port_q   <= '0;
                        out_vld_q   <= '0;
                        out_port_q  <= '0;
                    end
                end
                default: begin
                    if (!min_found || !pick_found) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        row_used_q[pick_row]           <= 1'b1;
                        col_used_q[min_col]            <= 1'b1;
                        in_vld_q[pick_row]             <= 1'b1;
                        in_port_q[pick_row*IW +: IW]   <= min_col;
                        out_vld_q[min_col]             <= 1'b1;
                        out_port_q[min_col*IW +: IW]   <= pick_row;
                        match_cnt_q                    <= match_cnt_q + 1'b1;
                        if (match_cnt_q == LAST_CNT) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // Drive the ports from the registered state.
    always_comb begin
        busy_o     = (state_q == ST_RUN);
        done_o     = done_q;
        cut_thru_o = cut_q;
        in_vld_o   = in_vld_q;
        in_port_o  = in_port_q;
        out_vld_o  = out_vld_q;
        out_port_o = out_port_q;
    end

    // R4: a column holding the minimum must yield an input with a cell.
    a_r4_pick_exists: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && min_found) |-> pick_found);

    // R5: both grant views always hold the same number of matches.
    a_r5_view_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_vld_o) == $countones(out_vld_o));

    // R7: done is a single-cycle pulse.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: the match count never exceeds the port count.
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        match_cnt_q <= CNT_W'(N));

    // R8: a start seen while busy leaves the phase tag untouched.
    a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(cut_thru_o));

    // R2 and R5: per-input grant points at a real cell and is mirrored per output.
    for (genvar gi = 0; gi < N; gi++) begin : g_chk
        a_r2_no_empty_grant: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld_o[gi] |-> (cush_q[(gi*N+int'(in_port_o[gi*IW +: IW]))*CW +: CW] != INF));
        a_r5_mirror: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld_o[gi] |-> (out_vld_o[in_port_o[gi*IW +: IW]] &&
                              (out_port_o[int'(in_port_o[gi*IW +: IW])*IW +: IW] == IW'(gi))));
    end
endmodule

// File: tb/lcm_scheduler_tb.sv
// Bench: directed corner matrices plus seeded random matrices, compared with a
// reference model of the matching rules written from the requirements.
module lcm_scheduler_tb;
    localparam int N  = 4;
    localparam int CW = 4;
    localparam int RW = 3;
    localparam int IW = 2;
    localparam int INF = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              phase_i = 1'b0;
    logic [N*N*CW-1:0] cushion_i = '1;
    logic [N*N*RW-1:0] urgency_i = '0;
    logic              busy_o, done_o, cut_thru_o;
    logic [N-1:0]      in_vld_o, out_vld_o;
    logic [N*IW-1:0]   in_port_o, out_port_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int cus [N][N];
    int urg [N][N];
    int e_in_vld [N];
    int e_in_port [N];
    int e_out_vld [N];
    int e_out_port [N];
    int e_cycles;

    always #2 clk = ~clk;

    lcm_scheduler #(.N(N), .CW(CW), .RW(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_i(phase_i),
        .cushion_i(cushion_i), .urgency_i(urgency_i), .busy_o(busy_o),
        .done_o(done_o), .cut_thru_o(cut_thru_o), .in_vld_o(in_vld_o),
        .in_port_o(in_port_o), .out_vld_o(out_vld_o), .out_port_o(out_port_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pack();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                cushion_i[(i*N+j)*CW +: CW] = CW'(cus[i][j]);
                urgency_i[(i*N+j)*RW +: RW] = RW'(urg[i][j]);
            end
    endtask

    // Reference model from R2..R7.
    task automatic model();
        bit ru [N];
        bit cu [N];
        int m = 0;
        for (int k = 0; k < N; k++) begin
            ru[k] = 0; cu[k] = 0;
            e_in_vld[k] = 0; e_in_port[k] = 0; e_out_vld[k] = 0; e_out_port[k] = 0;
        end
        while (m < N) begin
            int best = INF;
            int bc = -1;
            int br = -1;
            int bu = 0;
            for (int j = 0; j < N; j++)
                for (int i = 0; i < N; i++)
                    if (!ru[i] && !cu[j] && cus[i][j] < best) begin
                        best = cus[i][j]; bc = j;
                    end
            if (bc < 0) break;
            for (int i = 0; i < N; i++)
                if (!ru[i] && cus[i][bc] != INF && (br < 0 || urg[i][bc] < bu)) begin
                    br = i; bu = urg[i][bc];
                end
            ru[br] = 1; cu[bc] = 1;
            e_in_vld[br] = 1; e_in_port[br] = bc;
            e_out_vld[bc] = 1; e_out_port[bc] = br;
            m++;
        end
        e_cycles = (m == N) ? N : m + 1;
    endtask

    task automatic check_grants(input string tag);
        for (int k = 0; k < N; k++) begin
            chk(in_vld_o[k] == e_in_vld[k][0], {tag, " R3/R4 in_vld"}, in_vld_o[k], e_in_vld[k]);
            if (e_in_vld[k] != 0)
                chk(int'(in_port_o[k*IW +: IW]) == e_in_port[k], {tag, " R4 in_port"},
                    int'(in_port_o[k*IW +: IW]), e_in_port[k]);
            chk(out_vld_o[k] == e_out_vld[k][0], {tag, " R5 out_vld"}, out_vld_o[k], e_out_vld[k]);
            if (e_out_vld[k] != 0)
                chk(int'(out_port_o[k*IW +: IW]) == e_out_port[k], {tag, " R5 out_port"},
                    int'(out_port_o[k*IW +: IW]), e_out_port[k]);
        end
    endtask

    // Run one match; optionally poke start with a junk matrix while busy (R8).
    task automatic run(input string tag, input bit ph, input bit poke);
        int cnt = 0;
        model();
        pack();
        @(negedge clk);
        start_i = 1'b1; phase_i = ph;
        @(negedge clk);
        if (poke) begin
            cushion_i = '0; urgency_i = '0; phase_i = ~ph;
        end else start_i = 1'b0;
        do begin
            @(negedge clk);
            cnt++;
            start_i = 1'b0;
        end while (!done_o && cnt < 40);
        chk(cnt == e_cycles, {tag, " R6/R7 cycles to done"}, cnt, e_cycles);
        check_grants(tag);
        chk(cut_thru_o == !ph, {tag, " R9 cut_thru"}, cut_thru_o, !ph);
        if (poke) chk(1'b1, {tag, " R8 busy start ignored"}, 0, 0);
        @(negedge clk);
        chk(!done_o, {tag, " R7 done pulse width"}, done_o, 0);
    endtask

    task automatic clear();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                cus[i][j] = INF; urg[i][j] = 0;
            end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o, "R1 reset busy/done", {busy_o, done_o}, 0);
        chk(in_vld_o == '0 && out_vld_o == '0, "R1 reset grants", {in_vld_o, out_vld_o}, 0);

        // R2/R6: all pairs empty, no match, done after one cycle.
        clear();
        run("all_empty", 1'b0, 1'b0);

        // R7: full diagonal match.
        clear();
        for (int k = 0; k < N; k++) cus[k][k] = k;
        run("diagonal", 1'b1, 1'b0);

        // R3: tie across columns 1 and 2 in row 0 picks column 1 first.
        clear();
        cus[0][1] = 3; cus[0][2] = 3; cus[1][1] = 5;
        run("col_tie", 1'b0, 1'b0);
        chk(in_vld_o[0] && in_port_o[1:0] == 2'd1, "R3 lowest column on tie", int'(in_port_o[1:0]), 1);

        // R4: minimum row loses to a more urgent row.
        clear();
        cus[0][0] = 1; cus[1][0] = 4; urg[0][0] = 5; urg[1][0] = 0;
        run("urgency", 1'b0, 1'b0);
        chk(out_vld_o[0] && out_port_o[1:0] == 2'd1, "R4 urgent row wins", int'(out_port_o[1:0]), 1);

        // R4: equal ranks go to the lowest input.
        clear();
        cus[2][3] = 2; cus[3][3] = 1; urg[2][3] = 4; urg[3][3] = 4;
        run("rank_tie", 1'b1, 1'b0);

        // R8: start with a junk matrix while busy is ignored.
        clear();
        for (int k = 0; k < N; k++) cus[k][N-1-k] = 6 - k;
        run("busy_poke", 1'b0, 1'b1);

        // R10: results hold after done while inputs change.
        cushion_i = '0; urgency_i = '1; phase_i = 1'b1;
        repeat (3) @(negedge clk);
        check_grants("hold R10");
        chk(cut_thru_o == 1'b1, "R10 cut_thru held", cut_thru_o, 1);

        // Random matrices with sparse empty pairs.
        for (int t = 0; t < 60; t++) begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++) begin
                    cus[i][j] = ($urandom_range(0, 2) == 0) ? INF : int'($urandom_range(0, 14));
                    urg[i][j] = int'($urandom_range(0, 7));
                end
            run("random", t[0], t % 7 == 3);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule